// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small supply of code bytes ready for an instruction consumer. It sits between a 16-bit memory bus and that consumer. It holds up to six bytes and raises fetch requests on its own at the current code fetch address. It does not fetch again until there is room for a whole bus word. Fetch width follows the parity of the fetch address. An odd address yields one byte, taken from the upper lane of the bus. An even address yields a full aligned word, with the lower-address byte queued first.

The consumer takes one byte per pop and marks the first byte of each opcode with a strobe. A 2-bit status code is registered one clock after each queue operation, so an observer can follow the instruction stream. A flush, used after a jump or at start-up, empties the queue in a single cycle and loads a new 20-bit fetch address. Any bus response already on its way is thrown away when it arrives.

Top module: `prefetch_byte_queue`

## Requirements
- R1: The occupancy `q_level_o` never exceeds six bytes, and `q_valid_o` is high exactly when the occupancy is non-zero.
- R2: `bus_req_o` is high only when at least two slots are free, no fetch is outstanding and `flush_i` is low. It is high whenever all three conditions hold.
- R3: A fetch at an odd address has `bus_wide_o` low. Its response adds exactly one byte, `bus_rdata_i[15:8]`, and the fetch address then advances by one.
- R4: A fetch at an even address has `bus_wide_o` high. Its response adds `bus_rdata_i[7:0]` and then `bus_rdata_i[15:8]`, in that order, and the fetch address then advances by two.
- R5: In the cycle after `flush_i`, the queue is empty and `bus_addr_o` equals the `restart_addr_i` value sampled with the flush.
- R6: The response to a fetch that was accepted before a flush, and that arrives after that flush, adds no byte to the queue.
- R7: Bytes leave in the order they entered, with `q_byte_o` showing the oldest byte. The occupancy changes by pushed bytes minus popped bytes, including in a cycle that both pushes and pops.
- R8: A pop while the queue is empty is ignored, and `stall_o` is high in that same cycle.
- R9: `qs_o` reports the previous cycle's operation: 2'b10 for a flush (which wins over a pop), 2'b01 for a pop with `pop_first_i` high, 2'b11 for a pop with `pop_first_i` low, and 2'b00 otherwise.
- R10: After reset the queue is empty, the fetch address is the reset address (0xFFFF0 by default), `qs_o` is 2'b00 and no fetch is outstanding.
- R11: At most one fetch is outstanding. Once a request is accepted by `bus_ack_i`, no new request is raised until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and reload the fetch address |
| restart_addr_i | input | 20 | New fetch address used by a flush |
| bus_req_o | output | 1 | Fetch request |
| bus_addr_o | output | 20 | Byte address of the fetch |
| bus_wide_o | output | 1 | 1: two-byte fetch (even address), 0: one byte |
| bus_ack_i | input | 1 | Bus accepts the request in this cycle |
| bus_rvalid_i | input | 1 | Response data valid (at least one cycle after accept) |
| bus_rdata_i | input | 16 | Response word; low lane is even byte, high lane is odd byte |
| pop_i | input | 1 | Consumer takes the head byte |
| pop_first_i | input | 1 | The byte being popped starts an opcode |
| q_byte_o | output | 8 | Oldest byte in the queue |
| q_valid_o | output | 1 | Queue holds at least one byte |
| q_level_o | output | 3 | Number of bytes held |
| stall_o | output | 1 | Pop requested on an empty queue |
| qs_o | output | 2 | Registered status of the previous cycle's operation |

## Verification
The checker watches several rules on every cycle: the occupancy bound, the conditions for a request, the single outstanding fetch, the address step after an accepted odd or even fetch, the empty queue and new address after a flush, the flush status code, the status code after an empty pop, and the one-byte drop after a plain pop. The order and values of the bytes are shown only by the bench's scenarios. Those scenarios compare every byte at the head against a byte-addressed memory model, which exposes errors in lane selection and in byte order within a word. The discarding of a response that arrives after a flush, and the exact level in cycles where a push and a pop coincide, are also shown only by these reference-model scenarios, run across a range of bus latencies and pop rates.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int BUS_W   = BYTE_W * LANES;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

endpackage

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter int                DEPTH      = 6,
    parameter int                MIN_FREE   = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] restart_addr_i,
    input  logic [CNT_W-1:0]  level_i,
    input  logic              bus_ack_i,
    input  logic              bus_rvalid_i,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_wide_o,
    output logic [1:0]        push_cnt_o,
    output logic [BYTE_W-1:0] push_b0_o,
    output logic [BYTE_W-1:0] push_b1_o
);

    localparam logic [CNT_W-1:0]  ROOM_LIM = CNT_W'(DEPTH - MIN_FREE);
    localparam logic [ADDR_W-1:0] STEP_ODD = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_EVN = ADDR_W'(2);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              busy;
        logic              drop;
        logic              odd;
    } fstate_t;

    fstate_t st_d, st_q;

    logic              room;
    logic              req;
    logic              resp;
    logic [BYTE_W-1:0] lane_lo;
    logic [BYTE_W-1:0] lane_hi;

    assign lane_lo = bus_rdata_i[BYTE_W-1:0];
    assign lane_hi = bus_rdata_i[BUS_W-1:BYTE_W];

    always_comb begin
        st_d       = st_q;
        push_cnt_o = 2'd0;
        push_b0_o  = lane_hi;
        push_b1_o  = lane_hi;

        room = (level_i <= ROOM_LIM);
        req  = !st_q.busy && !flush_i && room;
        resp = st_q.busy && bus_rvalid_i;

        // a live response lands in the queue unless a flush coincides
        if (resp && !st_q.drop && !flush_i) begin
            if (st_q.odd) begin
                push_cnt_o = 2'd1;
                push_b0_o  = lane_hi;
            end else begin
                push_cnt_o = 2'd2;
                push_b0_o  = lane_lo;
                push_b1_o  = lane_hi;
            end
        end

        if (resp) begin
            st_d.busy = 1'b0;
            st_d.drop = 1'b0;
        end

        if (flush_i) begin
            st_d.addr = restart_addr_i;
            if (st_q.busy && !bus_rvalid_i) begin
                st_d.drop = 1'b1;
            end
        end else if (req && bus_ack_i) begin
            st_d.busy = 1'b1;
            st_d.odd  = st_q.addr[0];
            st_d.addr = st_q.addr + (st_q.addr[0] ? STEP_ODD : STEP_EVN);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.addr <= RESET_ADDR;
            st_q.busy <= 1'b0;
            st_q.drop <= 1'b0;
            st_q.odd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req_o  = req;
    assign bus_addr_o = st_q.addr;
    assign bus_wide_o = !st_q.addr[0];

endmodule

// File: rtl/pfq_byte_ring.sv
module pfq_byte_ring
    import pfq_pkg::*;
#(
    parameter int  DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [1:0]        push_cnt_i,
    input  logic [BYTE_W-1:0] push_b0_i,
    input  logic [BYTE_W-1:0] push_b1_i,
    input  logic              pop_i,
    output logic              pop_ok_o,
    output logic              stall_o,
    output logic [BYTE_W-1:0] head_o,
    output logic              valid_o,
    output logic [CNT_W-1:0]  level_o
);

    localparam logic [PTR_W:0] SLOTS = (PTR_W + 1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             level;
    } rstate_t;

    rstate_t st_d, st_q;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [1:0]       n);
        logic [PTR_W:0] s;
        s = {1'b0, p} + {{(PTR_W - 1){1'b0}}, n};
        if (s >= SLOTS) begin
            s = s - SLOTS;
        end
        return s[PTR_W-1:0];
    endfunction

    logic [PTR_W-1:0] wr_nxt1;
    logic [DEPTH-1:0] we_first;
    logic [DEPTH-1:0] we_second;
    logic             empty;

    assign wr_nxt1 = wrap_add(st_q.wr, 2'd1);
    assign empty   = (st_q.level == '0);

    // per-slot write enables: first pushed byte at wr, second at wr+1
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign we_first[g]  = (push_cnt_i != 2'd0) && (st_q.wr == PTR_W'(g));
        assign we_second[g] = (push_cnt_i == 2'd2) && (wr_nxt1 == PTR_W'(g));
    end

    assign pop_ok_o = pop_i && !empty && !flush_i;
    assign stall_o  = pop_i && empty;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.rd    = '0;
            st_d.wr    = '0;
            st_d.level = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we_first[i]) begin
                    st_d.mem[i] = push_b0_i;
                end else if (we_second[i]) begin
                    st_d.mem[i] = push_b1_i;
                end
            end
            if (pop_ok_o) begin
                st_d.rd = wrap_add(st_q.rd, 2'd1);
            end
            st_d.wr    = wrap_add(st_q.wr, push_cnt_i);
            st_d.level = st_q.level
                       + {{(CNT_W - 2){1'b0}}, push_cnt_i}
                       - {{(CNT_W - 1){1'b0}}, pop_ok_o};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mem   <= '0;
            st_q.rd    <= '0;
            st_q.wr    <= '0;
            st_q.level <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign valid_o = !empty;
    assign level_o = st_q.level;

endmodule

// File: rtl/pfq_status.sv
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       flush_i,
    input  logic       pop_ok_i,
    input  logic       first_i,
    output logic [1:0] qs_o
);

    typedef struct packed {
        qstat_e qs;
    } sstate_t;

    sstate_t st_d, st_q;

    always_comb begin
        st_d.qs = QS_IDLE;
        if (flush_i) begin
            st_d.qs = QS_FLUSH;
        end else if (pop_ok_i) begin
            st_d.qs = first_i ? QS_FIRST : QS_NEXT;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.qs <= QS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign qs_o = st_q.qs;

endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 20,
    parameter int                DEPTH      = 6,
    parameter int                MIN_FREE   = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 20'hFFFF0,
    localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] restart_addr_i,
    output logic              bus_req_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_wide_o,
    input  logic              bus_ack_i,
    input  logic              bus_rvalid_i,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    input  logic              pop_i,
    input  logic              pop_first_i,
    output logic [BYTE_W-1:0] q_byte_o,
    output logic              q_valid_o,
    output logic [CNT_W-1:0]  q_level_o,
    output logic              stall_o,
    output logic [1:0]        qs_o
);

    logic [1:0]        push_cnt;
    logic [BYTE_W-1:0] push_b0;
    logic [BYTE_W-1:0] push_b1;
    logic              pop_ok;
    logic [CNT_W-1:0]  level;

    pfq_fetch_ctl #(
        .ADDR_W     (ADDR_W),
        .DEPTH      (DEPTH),
        .MIN_FREE   (MIN_FREE),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .flush_i        (flush_i),
        .restart_addr_i (restart_addr_i),
        .level_i        (level),
        .bus_ack_i      (bus_ack_i),
        .bus_rvalid_i   (bus_rvalid_i),
        .bus_rdata_i    (bus_rdata_i),
        .bus_req_o      (bus_req_o),
        .bus_addr_o     (bus_addr_o),
        .bus_wide_o     (bus_wide_o),
        .push_cnt_o     (push_cnt),
        .push_b0_o      (push_b0),
        .push_b1_o      (push_b1)
    );

    pfq_byte_ring #(
        .DEPTH (DEPTH)
    ) u_ring (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush_i),
        .push_cnt_i (push_cnt),
        .push_b0_i  (push_b0),
        .push_b1_i  (push_b1),
        .pop_i      (pop_i),
        .pop_ok_o   (pop_ok),
        .stall_o    (stall_o),
        .head_o     (q_byte_o),
        .valid_o    (q_valid_o),
        .level_o    (level)
    );

    pfq_status u_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flush_i  (flush_i),
        .pop_ok_i (pop_ok),
        .first_i  (pop_first_i),
        .qs_o     (qs_o)
    );

    assign q_level_o = level;

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int  ADDR_W = 20,
    parameter int  DEPTH  = 6,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              flush_i,
    input logic [ADDR_W-1:0] restart_addr_i,
    input logic              bus_req_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_ack_i,
    input logic              bus_rvalid_i,
    input logic              pop_i,
    input logic              q_valid_o,
    input logic [CNT_W-1:0]  q_level_o,
    input logic [1:0]        qs_o
);

    localparam logic [CNT_W-1:0]  CAP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  LIM  = CNT_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO  = ADDR_W'(2);

    // R1
    p_level_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_level_o <= CAP);

    // R2
    p_req_room_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> (q_level_o <= LIM) && !flush_i);

    // R11
    p_one_outstanding_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_ack_i) |=> !bus_req_o);

    // R3
    p_odd_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_ack_i && bus_addr_o[0]) |=> bus_addr_o == $past(bus_addr_o) + ONE);

    // R4
    p_even_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_ack_i && !bus_addr_o[0]) |=> bus_addr_o == $past(bus_addr_o) + TWO);

    // R5
    p_flush_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (q_level_o == '0) && !q_valid_o && (bus_addr_o == $past(restart_addr_i)));

    // R9
    p_flush_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> qs_o == 2'b10);

    // R8
    p_empty_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !q_valid_o && !flush_i) |=> qs_o == 2'b00);

    // R7
    p_pop_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && q_valid_o && !flush_i && !bus_rvalid_i) |=> q_level_o == $past(q_level_o) - 1'b1);

endmodule

bind prefetch_byte_queue pfq_checker #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .restart_addr_i (restart_addr_i),
    .bus_req_o      (bus_req_o),
    .bus_addr_o     (bus_addr_o),
    .bus_ack_i      (bus_ack_i),
    .bus_rvalid_i   (bus_rvalid_i),
    .pop_i          (pop_i),
    .q_valid_o      (q_valid_o),
    .q_level_o      (q_level_o),
    .qs_o           (qs_o)
);

// File: tb/sim_prefetch_byte_queue.sv
module sim_prefetch_byte_queue;

    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] RST_ADDR = 20'hFFFF0;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        flush_i = 1'b0;
    logic [19:0] restart_addr_i = '0;
    logic        bus_req_o;
    logic [19:0] bus_addr_o;
    logic        bus_wide_o;
    logic        bus_ack_i = 1'b0;
    logic        bus_rvalid_i = 1'b0;
    logic [15:0] bus_rdata_i = '0;
    logic        pop_i = 1'b0;
    logic        pop_first_i = 1'b0;
    logic [7:0]  q_byte_o;
    logic        q_valid_o;
    logic [2:0]  q_level_o;
    logic        stall_o;
    logic [1:0]  qs_o;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    prefetch_byte_queue u0 (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .flush_i        (flush_i),
        .restart_addr_i (restart_addr_i),
        .bus_req_o      (bus_req_o),
        .bus_addr_o     (bus_addr_o),
        .bus_wide_o     (bus_wide_o),
        .bus_ack_i      (bus_ack_i),
        .bus_rvalid_i   (bus_rvalid_i),
        .bus_rdata_i    (bus_rdata_i),
        .pop_i          (pop_i),
        .pop_first_i    (pop_first_i),
        .q_byte_o       (q_byte_o),
        .q_valid_o      (q_valid_o),
        .q_level_o      (q_level_o),
        .stall_o        (stall_o),
        .qs_o           (qs_o)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  mq[$];
    logic [19:0] mfa;
    bit          m_busy, m_drop, m_odd;
    logic [19:0] m_raddr;
    logic [1:0]  exp_qs;
    bit          after_flush, dropped_last;
    // bus model state
    bit          bpend;
    int          bcnt;
    logic [19:0] baddr;
    int          lat_cfg = 1;
    bit          ack_en = 1;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] mword(input logic [19:0] a);
        return {mbyte({a[19:1], 1'b1}), mbyte({a[19:1], 1'b0})};
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input bit fl, input logic [19:0] ra, input bit pp, input bit fb);
        bit rv, ackv, resp, exp_req;
        int sz;
        flush_i = fl; restart_addr_i = ra; pop_i = pp; pop_first_i = fb;
        rv = bpend && (bcnt == 0);
        bus_rvalid_i = rv;
        bus_rdata_i = rv ? mword(baddr) : 16'h0;
        bus_ack_i = 1'b0;
        #1;
        sz = mq.size();
        check(qs_o == exp_qs, "R9 status", qs_o, exp_qs);
        check(int'(q_level_o) <= 6, "R1 level cap", q_level_o, 6);
        check(int'(q_level_o) == sz, dropped_last ? "R6 level after dropped reply" :
              (after_flush ? "R5 level after flush" : "R7 level"), q_level_o, sz);
        check(q_valid_o == (sz > 0), "R1 valid", q_valid_o, sz > 0);
        if (sz > 0) check(q_byte_o == mq[0], "R7 head byte", q_byte_o, mq[0]);
        check(stall_o == (pp && sz == 0), "R8 stall", stall_o, pp && sz == 0);
        exp_req = !m_busy && (sz <= 4) && !fl;
        check(bus_req_o == exp_req, "R2 R11 request", bus_req_o, exp_req);
        if (exp_req) begin
            check(bus_addr_o == mfa, after_flush ? "R5 fetch address" :
                  (mfa[0] ? "R3 fetch address" : "R4 fetch address"), bus_addr_o, mfa);
            check(bus_wide_o == !mfa[0], mfa[0] ? "R3 narrow" : "R4 wide", bus_wide_o, !mfa[0]);
        end
        ackv = bus_req_o && ack_en;
        bus_ack_i = ackv;
        // model update for the coming edge
        exp_qs = fl ? 2'b10 : ((pp && sz > 0) ? (fb ? 2'b01 : 2'b11) : 2'b00);
        after_flush = fl;
        dropped_last = 0;
        resp = m_busy && rv;
        if (fl) begin
            mq.delete();
            if (resp) begin m_busy = 0; m_drop = 0; end
            else if (m_busy) m_drop = 1;
            mfa = ra;
        end else begin
            if (pp && sz > 0) void'(mq.pop_front());
            if (resp) begin
                if (!m_drop) begin
                    mq.push_back(mbyte(m_raddr));
                    if (!m_odd) mq.push_back(mbyte(m_raddr + 20'd1));
                end
                dropped_last = m_drop;
                m_busy = 0; m_drop = 0;
            end
            if (ackv) begin
                m_busy = 1; m_odd = mfa[0]; m_raddr = mfa;
                mfa = mfa + (mfa[0] ? 20'd1 : 20'd2);
            end
        end
        if (rv) bpend = 0;
        if (ackv) begin bpend = 1; bcnt = lat_cfg - 1; baddr = bus_addr_o; end
        else if (bpend && !rv) bcnt--;
        @(posedge clk_i); #1;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        mfa = RST_ADDR; exp_qs = 2'b00;
        repeat (3) @(posedge clk_i);
        #1;
        // R10: reset state
        check(q_level_o == 0, "R10 level", q_level_o, 0);
        check(!q_valid_o, "R10 valid", q_valid_o, 0);
        check(qs_o == 2'b00, "R10 status", qs_o, 0);
        check(bus_addr_o == RST_ADDR, "R10 address", bus_addr_o, RST_ADDR);
        rst_ni = 1'b1;
        @(posedge clk_i); #1;

        // directed: fill from even reset address without popping
        for (int i = 0; i < 12; i++) tick(0, 0, 0, 0);
        check(q_level_o == 6, "R1 full queue", q_level_o, 6);
        // directed: odd restart, drain with first-byte marks
        tick(1, 20'h12345, 0, 0);
        for (int i = 0; i < 10; i++) tick(0, 0, 1, (i % 3) == 0);
        // directed R6: flush while a long fetch is outstanding
        lat_cfg = 4;
        tick(1, 20'h00100, 0, 0);
        tick(0, 0, 0, 0);
        tick(1, 20'h00201, 0, 0);
        for (int i = 0; i < 8; i++) tick(0, 0, 0, 0);
        // pops on empty queue with slow bus
        tick(1, 20'h00400, 1, 1);
        for (int i = 0; i < 6; i++) tick(0, 0, 1, 0);

        // sweep: latency x pop rate x ack availability
        for (int lat = 1; lat <= 4; lat++) begin
            for (int rate = 0; rate < 4; rate++) begin
                for (int ae = 0; ae < 2; ae++) begin
                    lat_cfg = lat;
                    for (int c = 0; c < 250; c++) begin
                        bit fl, pp;
                        step_lfsr();
                        ack_en = (ae == 0) ? 1'b1 : lfsr[7];
                        pp = (int'(lfsr[1:0]) < rate) || (rate == 3);
                        fl = (lfsr[15:10] == 6'd0);
                        tick(fl, {lfsr[3:0], lfsr}, pp, lfsr[5]);
                    end
                end
            end
        end
        ack_en = 1;
        tick(0, 0, 0, 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            finish_run();
        end
    end

endmodule